// File: doc/BRIEF.md
# Receive Character Queue with Per-Character Error Status

This block sits between a serial receiver's deframer and the register interface of a serial port. Every received character is stored together with its own parity-error, framing-error and break flags. A character with an error therefore stays marked as it moves through the queue, and the error becomes visible only when that character reaches the head. The block produces a five-bit line status word, a data-ready flag and a line status interrupt.

The block has two modes. In queue mode it holds up to `DEPTH` characters. In single mode it acts as one holding register. The status error bits stay set until software reads the status word. Software reads the status word first and then pops the erroneous character with the data-read strobe. The characters ahead of it must be popped before its flags appear. If a character arrives while storage is full, it is dropped and an overrun is recorded. The deframer can also report an overrun directly.

Top module: `rx_status_fifo`

## Requirements
- R1: In queue mode up to DEPTH characters (default 16) are held and delivered in arrival order. Each character keeps the three error flags it was written with.
- R2: The status word `status_o` has this encoding: bit 4 parity error, bit 3 framing error, bit 2 break, bit 1 overrun, bit 0 data-ready.
- R3: Bits 4:2 show only the flags of the character at the head. A flagged character behind the head adds nothing to them until every character ahead of it has been popped.
- R4: Once set, bits 4:1 stay set until a cycle with `lsr_rd_i` high, which clears them. A setting condition in that same cycle wins. Popping an erroneous character without a status read leaves its flags set.
- R5: A write that arrives while storage is full is discarded and sets bit 1. A pulse on `ovr_pulse_i` also sets bit 1.
- R6: Bit 0 and `data_ready_o` are high exactly when at least one character is held. They are not sticky.
- R7: `irq_o` is high exactly when `lsi_en_i` is high and any of status bits 4:1 is set.
- R8: In single mode (`fifo_en_i` low) the storage holds one character. A second write before a pop is discarded as an overrun.
- R9: A change of `fifo_en_i` empties the storage. Sticky status bits are not affected.
- R10: `rd_data_o` shows the head character, or zero when the storage is empty. A data-read strobe on empty storage has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Deframer delivers a character |
| wr_data_i | input | DATA_W | Received character |
| wr_pe_i | input | 1 | Parity error of the character |
| wr_fe_i | input | 1 | Framing error of the character |
| wr_bi_i | input | 1 | Break detected with the character |
| ovr_pulse_i | input | 1 | Overrun reported by the deframer |
| rd_data_i | input | 1 | Pop the head character |
| lsr_rd_i | input | 1 | Status word read, clears sticky bits |
| fifo_en_i | input | 1 | 1 = queue mode, 0 = single mode |
| lsi_en_i | input | 1 | Line status interrupt enable |
| rd_data_o | output | DATA_W | Head character |
| status_o | output | 5 | Line status word |
| data_ready_o | output | 1 | At least one character held |
| irq_o | output | 1 | Line status interrupt |

## Verification
A table of mixed clean and flagged characters is written, popped and status-read in turn. This shows whether flags follow their own character, whether a flagged character hidden behind a clean head stays invisible, and whether a pop without a status read keeps the flags set. Filling the queue to capacity and writing once more separates a discarded character from one that wraps over older data. The same write pattern in single mode shows that capacity follows the mode. Overrun pulses with the enable low and then high separate the status bit from the interrupt gating, and a status read in the same cycle as an overrun pulse shows which of the two wins.

// File: rtl/rxsf_pkg.sv
package rxsf_pkg;
  typedef struct packed {
    logic pe;
    logic fe;
    logic bi;
  } err_t;

  localparam int unsigned ST_PE = 4;
  localparam int unsigned ST_FE = 3;
  localparam int unsigned ST_BI = 2;
  localparam int unsigned ST_OE = 1;
  localparam int unsigned ST_DR = 0;
  localparam int unsigned ST_W  = 5;
endpackage

// File: rtl/rxsf_store.sv
module rxsf_store
  import rxsf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  err_t              werr_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output err_t              head_err_o,
  output logic              head_valid_o,
  output logic              drop_o,
  output logic              popped_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DATA_W + 3;
  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q, cap;
  logic          full, do_push, do_pop;

  // single mode limits occupancy to one entry
  assign cap     = fifo_en_i ? CAP_Q : CW'(1);
  assign full    = cnt_q >= cap;
  assign do_push = push_i & ~full & ~flush_i;
  assign do_pop  = pop_i & (cnt_q != '0) & ~flush_i;
  assign drop_o  = push_i & full & ~flush_i;
  assign popped_o = do_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= {wdata_i, werr_i};
  end

  logic [EW-1:0] head;
  assign head_valid_o = cnt_q != '0;
  assign head         = head_valid_o ? mem[rd_ptr_q] : '0;
  assign head_data_o  = head[EW-1:3];
  assign head_err_o   = head[2:0];
endmodule

// File: rtl/rxsf_status.sv
module rxsf_status
  import rxsf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            head_valid_i,
  input  err_t            head_err_i,
  input  logic            popped_i,
  input  logic            flush_i,
  input  logic            lsr_rd_i,
  input  logic            ovr_evt_i,
  input  logic            irq_en_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  err_t sticky_q, shown;
  logic reported_q, ovr_q;

  // head flags count once per head entry, then live in sticky_q
  assign shown = (head_valid_i && !reported_q) ? head_err_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q   <= '0;
      reported_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (lsr_rd_i) sticky_q <= '0;
      else          sticky_q <= sticky_q | shown;

      if (popped_i || flush_i) reported_q <= 1'b0;
      else if (head_valid_i)   reported_q <= 1'b1;

      if (ovr_evt_i)     ovr_q <= 1'b1;
      else if (lsr_rd_i) ovr_q <= 1'b0;
    end
  end

  err_t err_view;
  assign err_view         = sticky_q | shown;
  assign status_o[ST_PE]  = err_view.pe;
  assign status_o[ST_FE]  = err_view.fe;
  assign status_o[ST_BI]  = err_view.bi;
  assign status_o[ST_OE]  = ovr_q;
  assign status_o[ST_DR]  = head_valid_i;
  assign irq_o            = irq_en_i & (|status_o[ST_PE:ST_OE]);
endmodule

// File: rtl/rx_status_fifo.sv
module rx_status_fifo
  import rxsf_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_pe_i,
  input  logic              wr_fe_i,
  input  logic              wr_bi_i,
  input  logic              ovr_pulse_i,
  input  logic              rd_data_i,
  input  logic              lsr_rd_i,
  input  logic              fifo_en_i,
  input  logic              lsi_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [4:0]        status_o,
  output logic              data_ready_o,
  output logic              irq_o
);
  logic mode_q, flush, head_valid, drop, popped;
  err_t werr, head_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= fifo_en_i;
  end
  assign flush = mode_q ^ fifo_en_i;
  assign werr  = '{pe: wr_pe_i, fe: wr_fe_i, bi: wr_bi_i};

  rxsf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_en_i   (fifo_en_i),
    .flush_i     (flush),
    .push_i      (wr_valid_i),
    .wdata_i     (wr_data_i),
    .werr_i      (werr),
    .pop_i       (rd_data_i),
    .head_data_o (rd_data_o),
    .head_err_o  (head_err),
    .head_valid_o(head_valid),
    .drop_o      (drop),
    .popped_o    (popped)
  );

  rxsf_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .head_valid_i(head_valid),
    .head_err_i  (head_err),
    .popped_i    (popped),
    .flush_i     (flush),
    .lsr_rd_i    (lsr_rd_i),
    .ovr_evt_i   (drop | ovr_pulse_i),
    .irq_en_i    (lsi_en_i),
    .status_o    (status_o),
    .irq_o       (irq_o)
  );

  assign data_ready_o = head_valid;
endmodule

// File: rtl/rxsf_chk.sv
module rxsf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic       ovr_pulse_i,
  input logic       lsr_rd_i,
  input logic       lsi_en_i,
  input logic [4:0] status_o,
  input logic       data_ready_o,
  input logic       irq_o
);
  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lsi_en_i |-> !irq_o);

  p_ovr_pulse_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_pulse_i |=> status_o[1]);

  p_ovr_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && !lsr_rd_i) |=> status_o[1]);

  p_pe_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && !lsr_rd_i) |=> status_o[4]);

  p_lsr_clears_ovr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !ovr_pulse_i && !wr_valid_i) |=> !status_o[1]);

  p_no_phantom_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_ready_o && !wr_valid_i) |=> !data_ready_o);

  p_dr_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == data_ready_o);
endmodule

bind rx_status_fifo rxsf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .ovr_pulse_i (ovr_pulse_i),
  .lsr_rd_i    (lsr_rd_i),
  .lsi_en_i    (lsi_en_i),
  .status_o    (status_o),
  .data_ready_o(data_ready_o),
  .irq_o       (irq_o)
);

// File: tb/sim_rx_status_fifo.sv
`timescale 1ns/1ps
module sim_rx_status_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 0, pe = 0, fe = 0, bi = 0, ovr = 0, pop = 0, lsr = 0;
  logic       fifo_en = 1'b1, ie = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [4:0] status;
  logic       dr, irq;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  rx_status_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wdata),
    .wr_pe_i(pe), .wr_fe_i(fe), .wr_bi_i(bi), .ovr_pulse_i(ovr),
    .rd_data_i(pop), .lsr_rd_i(lsr), .fifo_en_i(fifo_en), .lsi_en_i(ie),
    .rd_data_o(rd_data), .status_o(status), .data_ready_o(dr), .irq_o(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // one operation held for one clock edge, outputs sampled on the next low phase
  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] f,
                      input logic p, input logic l, input logic o);
    @(negedge clk);
    wr_valid = w; wdata = d; {pe, fe, bi} = f; pop = p; lsr = l; ovr = o;
    @(negedge clk);
    wr_valid = 0; pop = 0; lsr = 0; ovr = 0; {pe, fe, bi} = '0;
  endtask

  // op: 0 write, 1 pop, 2 status read; then data, flags{pe,fe,bi}, exp status, exp data, exp irq
  localparam logic [26:0] VEC [8] = '{
    {2'd0, 8'h11, 3'b000, 5'b00001, 8'h11, 1'b0},
    {2'd0, 8'h22, 3'b100, 5'b00001, 8'h11, 1'b0},
    {2'd0, 8'h33, 3'b011, 5'b00001, 8'h11, 1'b0},
    {2'd1, 8'h00, 3'b000, 5'b10001, 8'h22, 1'b1},
    {2'd2, 8'h00, 3'b000, 5'b00001, 8'h22, 1'b0},
    {2'd1, 8'h00, 3'b000, 5'b01101, 8'h33, 1'b1},
    {2'd1, 8'h00, 3'b000, 5'b01100, 8'h00, 1'b1},
    {2'd2, 8'h00, 3'b000, 5'b00000, 8'h00, 1'b0}
  };

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset status", status, 0);
    chk("R6 reset data_ready", dr, 0);
    chk("R10 reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R4: flags follow their own character to the head
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][26:25] == 2'd0, VEC[i][24:17], VEC[i][16:14],
           VEC[i][26:25] == 2'd1, VEC[i][26:25] == 2'd2, 1'b0);
      chk("R3 vec status", status, VEC[i][13:9]);
      chk("R1 vec data", rd_data, VEC[i][8:1]);
      chk("R7 vec irq", irq, VEC[i][0]);
    end

    // R10: pop on empty storage
    step(0, 0, 0, 1, 0, 0);
    chk("R10 empty pop status", status, 0);
    chk("R10 empty pop data", rd_data, 0);

    // R5 R1: fill to DEPTH, one extra write is dropped
    for (int i = 0; i < 16; i++) step(1, 8'(8'h40 + i), 0, 0, 0, 0);
    step(1, 8'hAA, 0, 0, 0, 0);
    chk("R5 overrun on full", status, 5'b00011);
    chk("R7 irq on overrun", irq, 1);
    step(0, 0, 0, 0, 1, 0);
    chk("R4 status read clears overrun", status, 5'b00001);
    for (int i = 0; i < 16; i++) begin
      chk("R1 order", rd_data, 8'h40 + i);
      step(0, 0, 0, 1, 0, 0);
    end
    chk("R5 dropped char absent", dr, 0);
    chk("R6 data_ready falls", status, 0);

    // R8: single mode holds one character
    fifo_en = 1'b0;
    step(0, 0, 0, 0, 0, 0);
    step(1, 8'h5A, 3'b100, 0, 0, 0);
    step(1, 8'hA5, 3'b000, 0, 0, 0);
    chk("R8 single mode status", status, 5'b10011);
    chk("R8 single mode data", rd_data, 8'h5A);
    step(0, 0, 0, 0, 1, 0);
    chk("R4 read before data", status, 5'b00001);
    step(0, 0, 0, 1, 0, 0);
    chk("R8 empty after one pop", status, 0);

    // R7: enable gating, R4 set wins over clear
    ie = 1'b0;
    step(0, 0, 0, 0, 0, 1);
    chk("R7 irq masked", irq, 0);
    chk("R5 ovr pulse", status, 5'b00010);
    ie = 1'b1;
    @(negedge clk);
    chk("R7 irq enabled", irq, 1);
    step(0, 0, 0, 0, 1, 1);
    chk("R4 set wins", status, 5'b00010);
    step(0, 0, 0, 0, 1, 0);
    chk("R4 cleared", status, 0);

    // R9: mode change empties storage
    fifo_en = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    step(1, 8'h77, 0, 0, 0, 0);
    chk("R9 held before switch", dr, 1);
    fifo_en = 1'b0;
    step(0, 0, 0, 0, 0, 0);
    chk("R9 flushed", dr, 0);
    chk("R9 data zero", rd_data, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule